// File: doc/BRIEF.md
# Hardware register read unit

This unit executes the instruction that lets user-mode code copy one privileged hardware register into a general-purpose register. It receives an instruction word with a valid strobe and decodes the word. It checks whether the access is allowed and whether the register number and sub-index are legal. Exactly one clock later it presents either a write to the destination register or a reserved-instruction exception.

The values that can be read are:
- the CPU number;
- the cache synchronisation step;
- the cycle counter and its resolution;
- the control and counter words of two performance counter pairs;
- a flag that says the paired atomic instructions are absent;
- a 64-bit user local register;
- one implementation-defined register.

Access is granted in two cases. The first is when the coprocessor-enabled flag is set. The second is when the mask bit that matches the register number is set.

Results are 64 bits wide. 32-bit sources are sign-extended. The atomics flag is zero-extended. The user local value is passed through whole when 64-bit operation is on, and is sign-extended from its low half when it is off.

Top module: `hwreg_read_unit`

## Requirements
- R1: While reset is asserted, and after it is released with no request, `wr_en` and `ri_exc` are low.
- R2: An accepted request produces its outcome on the outputs exactly one clock after the cycle in which `in_valid` is high, for one cycle only. With `in_valid` low, neither `wr_en` nor `ri_exc` is raised.
- R3: A word is accepted only when all of the following hold: bits 31:26 = 000000, bits 15:14 = 00, bit 10 = 0, and bits 9:0 = 0111000000. In an accepted word, `rt` is bits 25:21, `rs` is bits 20:16 and `sel` is bits 13:11, and `wr_rt` reports `rt`. Any other word causes no write and no exception.
- R4: For `rs` values 0 to 3, the result is the matching 32-bit source, sign-extended to 64 bits. The mapping is: 0 = CPU number, 1 = sync step, 2 = cycle count, 3 = count resolution.
- R5: For `rs`=5, the result is the atomics-absent flag in bit 0, with all other bits zero.
- R6: For `rs`=29, the result is the full 64-bit user local value when `mode64` is high. When `mode64` is low, it is the low 32 bits of that value, sign-extended.
- R7: For `rs`=30, the result is the implementation value, sign-extended. For `rs`=31 and for `rs` values 6 to 28, the unit raises an exception.
- R8: A legal register is readable when `cop_en` is high, or when bit `rs` of `hw_en_mask` is high. Otherwise the unit raises an exception.
- R9: For any `rs` other than 4, a nonzero `sel` raises an exception.
- R10: For `rs`=4, the pair index is `sel`/2. An even `sel` returns that pair's control word and an odd `sel` returns its counter word, both sign-extended. `sel` values 4 to 7 raise an exception.
- R11: When an exception is raised, `wr_en` stays low and `wr_data` reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| cop_en | input | 1 | Coprocessor enabled; grants every access |
| hw_en_mask | input | 32 | Per-register access enable, indexed by rs |
| cpu_num | input | 32 | CPU number source |
| sync_step | input | 32 | Cache sync step source |
| cycle_cnt | input | 32 | Cycle counter source |
| cnt_res | input | 32 | Counter resolution source |
| perf_ctl | input | 64 | Control words of the pairs, pair p at bits 32p+31:32p |
| perf_cnt | input | 64 | Counter words of the pairs, same packing |
| atom_absent | input | 1 | Paired atomics absent flag |
| user_local | input | 64 | User local register |
| impl_val | input | 32 | Implementation register 30 |
| mode64 | input | 1 | 64-bit operation enabled |
| wr_en | output | 1 | Destination write strobe |
| wr_rt | output | 5 | Destination register index |
| wr_data | output | 64 | Result |
| ri_exc | output | 1 | Reserved-instruction exception |

## Verification
The assertions assume that every source value and enable input is stable during the cycle in which `in_valid` is high. They make no assumption about later cycles, because the unit samples its inputs only once. The stimulus changes inputs only on the falling clock edge, before it raises `in_valid`. It covers every legal and illegal `rs` group and every `sel` value for the counter pair. It also covers malformed words and back-to-back requests. Source values are chosen with bit 31 set and clear, so that sign extension and zero extension are both observable.

// File: rtl/hwrr_pkg.sv
package hwrr_pkg;
  localparam int WORD_W = 32;
  localparam int IDX_W  = 5;
  localparam int SEL_W  = 3;

  localparam logic [5:0] MAJOR_OP = 6'b000000;
  localparam logic [9:0] MINOR_OP = 10'b0111000000;

  localparam logic [IDX_W-1:0] SRC_CPU   = 5'd0;
  localparam logic [IDX_W-1:0] SRC_STEP  = 5'd1;
  localparam logic [IDX_W-1:0] SRC_CYC   = 5'd2;
  localparam logic [IDX_W-1:0] SRC_RES   = 5'd3;
  localparam logic [IDX_W-1:0] SRC_PERF  = 5'd4;
  localparam logic [IDX_W-1:0] SRC_ATOM  = 5'd5;
  localparam logic [IDX_W-1:0] SRC_ULOC  = 5'd29;
  localparam logic [IDX_W-1:0] SRC_IMPL  = 5'd30;

  typedef struct packed {
    logic             match;
    logic [IDX_W-1:0] rt;
    logic [IDX_W-1:0] rs;
    logic [SEL_W-1:0] sel;
  } fields_t;
endpackage

// File: rtl/hwrr_decode.sv
module hwrr_decode
  import hwrr_pkg::*;
#(
  parameter int NPAIR = 2
) (
  input  logic [WORD_W-1:0] instr,
  input  logic              cop_en,
  input  logic [WORD_W-1:0] hw_en_mask,
  output fields_t           fld,
  output logic              legal
);
  localparam int SEL_LIMIT = 2 * NPAIR;

  logic implemented;
  logic granted;
  logic sel_ok;

  always_comb begin
    fld.match = (instr[31:26] == MAJOR_OP) && (instr[15:14] == 2'b00) &&
                (instr[10] == 1'b0) && (instr[9:0] == MINOR_OP);
    fld.rt    = instr[25:21];
    fld.rs    = instr[20:16];
    fld.sel   = instr[13:11];
  end

  always_comb begin
    unique case (fld.rs)
      SRC_CPU, SRC_STEP, SRC_CYC, SRC_RES,
      SRC_PERF, SRC_ATOM, SRC_ULOC, SRC_IMPL: implemented = 1'b1;
      default:                                implemented = 1'b0;
    endcase
    granted = cop_en | hw_en_mask[fld.rs];
    if (fld.rs == SRC_PERF) sel_ok = (int'(fld.sel) < SEL_LIMIT);
    else                    sel_ok = (fld.sel == '0);
    legal = implemented & granted & sel_ok;
  end
endmodule

// File: rtl/hwrr_source_mux.sv
module hwrr_source_mux
  import hwrr_pkg::*;
#(
  parameter int NPAIR = 2,
  parameter int XLEN  = 64
) (
  input  logic [IDX_W-1:0]        rs,
  input  logic [SEL_W-1:0]        sel,
  input  logic                    mode64,
  input  logic [WORD_W-1:0]       cpu_num,
  input  logic [WORD_W-1:0]       sync_step,
  input  logic [WORD_W-1:0]       cycle_cnt,
  input  logic [WORD_W-1:0]       cnt_res,
  input  logic [NPAIR*WORD_W-1:0] perf_ctl,
  input  logic [NPAIR*WORD_W-1:0] perf_cnt,
  input  logic                    atom_absent,
  input  logic [XLEN-1:0]         user_local,
  input  logic [WORD_W-1:0]       impl_val,
  output logic [XLEN-1:0]         value
);
  localparam int EXT_W = XLEN - WORD_W;

  logic [WORD_W-1:0] perf_word;
  logic [XLEN-1:0]   uloc_val;

  function automatic logic [XLEN-1:0] sext(input logic [WORD_W-1:0] v);
    return {{EXT_W{v[WORD_W-1]}}, v};
  endfunction

  always_comb begin
    perf_word = '0;
    for (int p = 0; p < NPAIR; p++) begin
      if (int'(sel[SEL_W-1:1]) == p)
        perf_word = sel[0] ? perf_cnt[p*WORD_W +: WORD_W]
                           : perf_ctl[p*WORD_W +: WORD_W];
    end
  end

  generate
    if (XLEN > WORD_W) begin : g_wide
      assign uloc_val = mode64 ? user_local : sext(user_local[WORD_W-1:0]);
    end else begin : g_narrow
      assign uloc_val = user_local;
    end
  endgenerate

  always_comb begin
    unique case (rs)
      SRC_CPU:  value = sext(cpu_num);
      SRC_STEP: value = sext(sync_step);
      SRC_CYC:  value = sext(cycle_cnt);
      SRC_RES:  value = sext(cnt_res);
      SRC_PERF: value = sext(perf_word);
      SRC_ATOM: value = {{(XLEN-1){1'b0}}, atom_absent};
      SRC_ULOC: value = uloc_val;
      SRC_IMPL: value = sext(impl_val);
      default:  value = '0;
    endcase
  end
endmodule

// File: rtl/hwreg_read_unit.sv
module hwreg_read_unit
  import hwrr_pkg::*;
#(
  parameter int NPAIR = 2,
  parameter int XLEN  = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [WORD_W-1:0]       instr,
  input  logic                    cop_en,
  input  logic [WORD_W-1:0]       hw_en_mask,
  input  logic [WORD_W-1:0]       cpu_num,
  input  logic [WORD_W-1:0]       sync_step,
  input  logic [WORD_W-1:0]       cycle_cnt,
  input  logic [WORD_W-1:0]       cnt_res,
  input  logic [NPAIR*WORD_W-1:0] perf_ctl,
  input  logic [NPAIR*WORD_W-1:0] perf_cnt,
  input  logic                    atom_absent,
  input  logic [XLEN-1:0]         user_local,
  input  logic [WORD_W-1:0]       impl_val,
  input  logic                    mode64,
  output logic                    wr_en,
  output logic [IDX_W-1:0]        wr_rt,
  output logic [XLEN-1:0]         wr_data,
  output logic                    ri_exc
);
  fields_t           fld;
  logic              legal;
  logic [XLEN-1:0]   src_val;
  logic              fire;
  logic              wr_en_d, ri_exc_d;
  logic [IDX_W-1:0]  wr_rt_d;
  logic [XLEN-1:0]   wr_data_d;

  hwrr_decode #(.NPAIR(NPAIR)) u_decode (
    .instr      (instr),
    .cop_en     (cop_en),
    .hw_en_mask (hw_en_mask),
    .fld        (fld),
    .legal      (legal)
  );

  hwrr_source_mux #(.NPAIR(NPAIR), .XLEN(XLEN)) u_mux (
    .rs          (fld.rs),
    .sel         (fld.sel),
    .mode64      (mode64),
    .cpu_num     (cpu_num),
    .sync_step   (sync_step),
    .cycle_cnt   (cycle_cnt),
    .cnt_res     (cnt_res),
    .perf_ctl    (perf_ctl),
    .perf_cnt    (perf_cnt),
    .atom_absent (atom_absent),
    .user_local  (user_local),
    .impl_val    (impl_val),
    .value       (src_val)
  );

  // next-state
  always_comb begin
    fire      = in_valid & fld.match;
    wr_en_d   = fire & legal;
    ri_exc_d  = fire & ~legal;
    wr_rt_d   = fld.rt;
    wr_data_d = legal ? src_val : '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en  <= 1'b0;
      ri_exc <= 1'b0;
    end else begin
      wr_en  <= wr_en_d;
      ri_exc <= ri_exc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_rt   <= '0;
      wr_data <= '0;
    end else if (fire) begin
      wr_rt   <= wr_rt_d;
      wr_data <= wr_data_d;
    end
  end

  // R2
  outcome_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || ri_exc) |-> $past(in_valid));

  // R11
  no_write_on_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ri_exc |-> (!wr_en && wr_data == '0));

  // R7
  reg31_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fld.match && instr[20:16] == 5'd31) |=> ri_exc);

  // R8
  denied_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fld.match && !cop_en && !hw_en_mask[instr[20:16]]) |=> ri_exc);

  // R9
  sel_nonzero_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fld.match && instr[20:16] != 5'd4 && instr[13:11] != 3'd0) |=> ri_exc);

  // R3
  foreign_word_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[31:26] != 6'd0) |=> (!wr_en && !ri_exc));
endmodule

// File: tb/test_hwreg_read_unit.sv
module test_hwreg_read_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] instr;
  logic        cop_en;
  logic [31:0] hw_en_mask;
  logic [31:0] cpu_num, sync_step, cycle_cnt, cnt_res, impl_val;
  logic [63:0] perf_ctl, perf_cnt, user_local;
  logic        atom_absent, mode64;
  logic        wr_en, ri_exc;
  logic [4:0]  wr_rt;
  logic [63:0] wr_data;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hwreg_read_unit i_hwreg_read_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .cop_en(cop_en), .hw_en_mask(hw_en_mask), .cpu_num(cpu_num),
    .sync_step(sync_step), .cycle_cnt(cycle_cnt), .cnt_res(cnt_res),
    .perf_ctl(perf_ctl), .perf_cnt(perf_cnt), .atom_absent(atom_absent),
    .user_local(user_local), .impl_val(impl_val), .mode64(mode64),
    .wr_en(wr_en), .wr_rt(wr_rt), .wr_data(wr_data), .ri_exc(ri_exc)
  );

  function automatic logic [31:0] mk(input int rt, input int rs, input int sel);
    return {6'b000000, 5'(rt), 5'(rs), 2'b00, 3'(sel), 1'b0, 10'b0111000000};
  endfunction

  function automatic logic [63:0] sx(input logic [31:0] v);
    return 64'($signed(v));
  endfunction

  // behavioural reference: expectation for the word currently driven
  logic        e_wr, e_exc;
  logic [4:0]  e_rt;
  logic [63:0] e_data;

  task automatic model();
    bit ok;
    int rs, sel;
    logic [63:0] v;
    bit ours;
    ours = in_valid && instr[31:26] == 0 && instr[15:14] == 0 &&
           instr[10] == 0 && instr[9:0] == 10'b0111000000;
    rs = int'(instr[20:16]);
    sel = int'(instr[13:11]);
    ok = 1; v = 0;
    case (rs)
      0: v = sx(cpu_num);
      1: v = sx(sync_step);
      2: v = sx(cycle_cnt);
      3: v = sx(cnt_res);
      4: begin
        if (sel >= 4) ok = 0;
        else if (sel % 2 == 0) v = sx(perf_ctl[(sel/2)*32 +: 32]);
        else v = sx(perf_cnt[(sel/2)*32 +: 32]);
      end
      5: v = {63'd0, atom_absent};
      29: v = mode64 ? user_local : sx(user_local[31:0]);
      30: v = sx(impl_val);
      default: ok = 0;
    endcase
    if (rs != 4 && sel != 0) ok = 0;
    if (!cop_en && !hw_en_mask[rs]) ok = 0;
    e_wr = ours && ok;
    e_exc = ours && !ok;
    e_rt = instr[25:21];
    e_data = v;
  endtask

  task automatic compare(input string tag);
    checks++;
    if (wr_en !== e_wr || ri_exc !== e_exc ||
        (e_wr && (wr_rt !== e_rt || wr_data !== e_data)) ||
        (e_exc && wr_data !== 64'd0)) begin
      errors++;
      $display("FAIL %s: wr=%b exc=%b rt=%0d data=%h expected wr=%b exc=%b rt=%0d data=%h",
               tag, wr_en, ri_exc, wr_rt, wr_data, e_wr, e_exc, e_rt,
               e_exc ? 64'd0 : e_data);
    end
  endtask

  // drive at falling edge, result appears after next rising edge
  task automatic issue(input string tag, input logic [31:0] w);
    instr = w;
    in_valid = 1'b1;
    model();
    @(negedge clk);
    compare(tag);
    in_valid = 1'b0;
  endtask

  task automatic idle(input string tag);
    in_valid = 1'b0;
    model();
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; instr = 0; cop_en = 1'b0; hw_en_mask = 0;
    cpu_num = 32'd3; sync_step = 32'h0000_0040; cycle_cnt = 32'h8000_1234;
    cnt_res = 32'd2; impl_val = 32'hF00D_0001; atom_absent = 1'b1; mode64 = 1'b1;
    perf_ctl = {32'h8000_0022, 32'h0000_0011};
    perf_cnt = {32'hFFFF_FF44, 32'h7FFF_FF33};
    user_local = 64'h1234_5678_9ABC_DEF0;
    repeat (3) @(negedge clk);
    // R1
    e_wr = 0; e_exc = 0; e_rt = 0; e_data = 0;
    compare("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after release");

    cop_en = 1'b1;
    issue("R4 cpu num", mk(7, 0, 0));
    issue("R4 sync step", mk(8, 1, 0));
    issue("R4 cycle count negative", mk(9, 2, 0));
    cycle_cnt = 32'h0000_ABCD;
    issue("R4 cycle count positive", mk(31, 2, 0));
    issue("R4 resolution", mk(1, 3, 0));
    issue("R5 atomics flag set", mk(2, 5, 0));
    atom_absent = 1'b0;
    issue("R5 atomics flag clear", mk(2, 5, 0));
    issue("R6 user local 64", mk(3, 29, 0));
    mode64 = 1'b0;
    issue("R6 user local 32 negative", mk(3, 29, 0));
    user_local = 64'hAAAA_0000_1111_2222;
    issue("R6 user local 32 positive", mk(3, 29, 0));
    mode64 = 1'b1;
    issue("R7 impl 30", mk(4, 30, 0));
    issue("R7 reg 31", mk(4, 31, 0));
    issue("R7 reg 6", mk(4, 6, 0));
    issue("R7 reg 28", mk(4, 28, 0));
    for (int s = 0; s < 8; s++) issue("R10 perf sel", mk(10 + s, 4, s));
    issue("R9 sel on cycle count", mk(5, 2, 1));
    issue("R9 sel on user local", mk(5, 29, 7));
    issue("R9 sel on impl", mk(5, 30, 4));

    cop_en = 1'b0;
    hw_en_mask = 32'h0000_0004;
    issue("R8 mask grants cycle count", mk(6, 2, 0));
    issue("R8 mask denies cpu num", mk(6, 0, 0));
    hw_en_mask = 32'h2000_0010;
    issue("R8 mask grants user local", mk(6, 29, 0));
    issue("R8 mask grants perf", mk(6, 4, 3));
    issue("R8 mask denies impl", mk(6, 30, 0));
    hw_en_mask = 32'hFFFF_FFFF;
    issue("R8 full mask reg 31 still illegal", mk(6, 31, 0));
    cop_en = 1'b1; hw_en_mask = 0;

    issue("R3 bad major opcode", mk(1, 2, 0) | 32'h0400_0000);
    issue("R3 bad bit 10", mk(1, 2, 0) | 32'h0000_0400);
    issue("R3 bad minor opcode", mk(1, 2, 0) ^ 32'h0000_0001);
    issue("R3 bad bits 15:14", mk(1, 2, 0) | 32'h0000_4000);
    idle("R2 idle after request");
    idle("R2 idle again");
    instr = mk(1, 2, 0);
    idle("R2 valid low with legal word");
    issue("R11 exception then write b2b", mk(12, 7, 0));
    issue("R11 write after exception", mk(13, 1, 0));
    idle("R2 single pulse");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule